// File: doc/BRIEF.md
# Miss-Triggered Coarse-Grain Thread Switcher

This controller lets an in-order pipeline run one hardware thread at a time and move to a different thread only when the running thread takes a long-latency miss in the second-level cache. Hits and first-level misses never reach this block. The cache side reports such a miss as a one-cycle event tagged with the thread that caused it. When the tag matches the running thread, the controller raises a flush of that thread's in-flight work, marks the thread as waiting on memory, and picks a new thread. Fetch stays off for a fixed refill penalty before the new thread issues.

Each thread stays blocked until its own miss-resolved line is pulsed, and a blocked thread is never chosen. The next thread is picked round-robin, starting at the slot after the current thread. If every thread is blocked, the controller stays on the current thread with fetch off, and switches as soon as any thread becomes ready. The flushed thread later resumes at the instruction that missed. Saving and restoring that PC is handled outside this block.

Top module: `coarse_thread_switcher`

## Requirements
- R1: After a synchronous active-low reset, `active_tid` is 0, `fetch_en` is 1, `flush_req` is 0 and no thread is blocked.
- R2: A miss is accepted only while fetch is enabled and `miss_tid` equals `active_tid`. A miss tagged with any other thread changes nothing.
- R3: `flush_req` is 1 for exactly the one cycle after the clock edge that accepts a miss, and 0 at all other times.
- R4: When a ready thread exists at the accepting edge, `active_tid` takes the new thread on that edge. `fetch_en` is then 0 for exactly PENALTY cycles (default 4), provided `pipe_empty` is 1 when the penalty ends.
- R5: `fetch_en` does not return to 1 while `pipe_empty` is 0. The penalty end is held off until `pipe_empty` is 1.
- R6: The new thread is the first ready thread found in the order current+1, current+2, … modulo NUM_THREADS.
- R7: A thread that missed stays blocked until its bit of `miss_done` (bit i for thread i) is 1 at a clock edge. A blocked thread is never selected.
- R8: When no thread is ready at the accepting edge, `active_tid` keeps its value and `fetch_en` stays 0 until some `miss_done` bit frees a thread. The controller then switches to the round-robin choice and applies the full penalty.
- R9: A miss that arrives while fetch is disabled (during a penalty or while waiting) is ignored. It neither blocks a thread nor flushes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | One-cycle second-level miss event |
| miss_tid | input | TW | Thread that took the miss (TW = clog2(NUM_THREADS)) |
| miss_done | input | NUM_THREADS | Per-thread miss-resolved pulses |
| pipe_empty | input | 1 | Pipeline holds no in-flight instructions |
| flush_req | output | 1 | Flush the in-flight instructions of the thread that missed |
| active_tid | output | TW | Thread currently owning the pipeline |
| fetch_en | output | 1 | Fetch allowed for the active thread |

## Verification
Directed sequences on a four-thread build walk the thread pointer through a chain of misses, so that every thread ends up blocked. This separates a plain round-robin step from a step that must skip a blocked slot, and a normal switch from the all-blocked wait. Further directed cases send a miss tagged with a non-running thread, a miss during the penalty, and a penalty with `pipe_empty` held low. These tell a correctly ignored event from one that leaks into state, and a fixed-length penalty from one that waits for drain. Seeded random traffic then mixes misses, which are biased towards the running thread, with sparse resolve pulses and intermittent pipeline-busy. A bench reference model catches ordering errors between blocking, unblocking and selection within the same cycle.

// File: rtl/cts_pkg.sv
// Shared types for the coarse-grain thread switcher.
package cts_pkg;
    // Controller phase: running, parked with nothing ready, or paying the penalty
    typedef enum logic [1:0] {
        CTS_RUN    = 2'd0,
        CTS_PARK   = 2'd1,
        CTS_REFILL = 2'd2
    } cts_phase_e;
endpackage

// File: rtl/cts_rr_pick.sv
// Round-robin picker: scans the ready vector starting at the slot after
// `cur` and wrapping back to `cur` last. Purely combinational.
// Assumes NUM_THREADS >= 2 and that cur is a valid thread index.
module cts_rr_pick #(
    parameter int NUM_THREADS = 2,
    parameter int TW          = 1
) (
    input  logic [NUM_THREADS-1:0] ready,
    input  logic [TW-1:0]          cur,
    output logic                   found,
    output logic [TW-1:0]          pick
);
    // Search for the first ready slot after the current one
    always_comb begin
        found = 1'b0;
        pick  = cur;
        for (int k = 1; k <= NUM_THREADS; k++) begin
            int slot;
            slot = (int'(cur) + k) % NUM_THREADS;
            if (!found && ready[slot]) begin
                found = 1'b1;
                pick  = TW'(slot);
            end
        end
    end
endmodule

// File: rtl/cts_block_track.sv
// Tracks which threads are waiting on memory. A set request wins over
// a clear for the same thread in the same cycle. Also exports the
// next-cycle view so that selection sees releases at once.
module cts_block_track #(
    parameter int NUM_THREADS = 2,
    parameter int TW          = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   set_en,
    input  logic [TW-1:0]          set_tid,
    input  logic [NUM_THREADS-1:0] clr,
    output logic [NUM_THREADS-1:0] blocked_q,
    output logic [NUM_THREADS-1:0] blocked_nxt
);
    logic [NUM_THREADS-1:0] set_mask;

    // Decode the set request into a one-hot mask
    always_comb begin
        for (int i = 0; i < NUM_THREADS; i++) begin
            set_mask[i] = set_en && (set_tid == TW'(i));
        end
    end

    // Next blocked view: release resolved misses, then add the new miss
    always_comb begin
        blocked_nxt = (blocked_q & ~clr) | set_mask;
    end

    // Hold the blocked vector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blocked_q <= '0;
        end else begin
            blocked_q <= blocked_nxt;
        end
    end
endmodule

// File: rtl/cts_penalty_timer.sv
// Down-counter for the refill penalty. Loading sets PENALTY-1, and the
// counter then falls to zero and rests there. `expired` is high at zero.
// Assumes PENALTY >= 1.
module cts_penalty_timer #(
    parameter int PENALTY = 4,
    localparam int CW     = (PENALTY > 1) ? $clog2(PENALTY) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    logic [CW-1:0] cnt_q;

    // Load on a switch, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CW'(PENALTY - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Zero count means the penalty has run out
    always_comb begin
        expired = (cnt_q == '0);
    end
endmodule

// File: rtl/coarse_thread_switcher.sv
// Top of the coarse-grain thread switcher. Runs one thread and, on an
// accepted long-latency miss from it, flushes, blocks that thread, and
// moves round-robin to a ready thread after a fixed penalty. With no
// ready thread it parks on the current thread with fetch off.
// Assumes miss_valid is a single-cycle event from the L2 miss logic and
// that miss_done pulses arrive only for outstanding misses.
module coarse_thread_switcher
    import cts_pkg::*;
#(
    parameter int NUM_THREADS = 2,
    parameter int PENALTY     = 4,
    localparam int TW         = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   miss_valid,
    input  logic [TW-1:0]          miss_tid,
    input  logic [NUM_THREADS-1:0] miss_done,
    input  logic                   pipe_empty,
    output logic                   flush_req,
    output logic [TW-1:0]          active_tid,
    output logic                   fetch_en
);
    cts_phase_e             phase_q, phase_d;
    logic [TW-1:0]          act_q, act_d;
    logic                   flush_q, flush_d;
    logic                   accept;
    logic                   load;
    logic                   expired;
    logic                   found;
    logic [TW-1:0]          pick;
    logic [NUM_THREADS-1:0] blocked_q, blocked_nxt;

    // Accept only a miss from the running thread while it is fetching
    always_comb begin
        accept = (phase_q == CTS_RUN) && miss_valid &&
                 (miss_tid == act_q) && (int'(miss_tid) < NUM_THREADS);
    end

    cts_block_track #(.NUM_THREADS(NUM_THREADS), .TW(TW)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_en      (accept),
        .set_tid     (miss_tid),
        .clr         (miss_done),
        .blocked_q   (blocked_q),
        .blocked_nxt (blocked_nxt)
    );

    cts_rr_pick #(.NUM_THREADS(NUM_THREADS), .TW(TW)) u_pick (
        .ready (~blocked_nxt),
        .cur   (act_q),
        .found (found),
        .pick  (pick)
    );

    cts_penalty_timer #(.PENALTY(PENALTY)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .expired (expired)
    );

    // Phase sequencing and thread selection
    always_comb begin
        phase_d = phase_q;
        act_d   = act_q;
        flush_d = 1'b0;
        load    = 1'b0;
        unique case (phase_q)
            CTS_RUN: begin
                if (accept) begin
                    flush_d = 1'b1;
                    if (found) begin
                        act_d   = pick;
                        phase_d = CTS_REFILL;
                        load    = 1'b1;
                    end else begin
                        phase_d = CTS_PARK;
                    end
                end
            end
            CTS_PARK: begin
                if (found) begin
                    act_d   = pick;
                    phase_d = CTS_REFILL;
                    load    = 1'b1;
                end
            end
            CTS_REFILL: begin
                if (expired && pipe_empty) begin
                    phase_d = CTS_RUN;
                end
            end
            default: phase_d = CTS_RUN;
        endcase
    end

    // Registered phase, active thread and flush pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= CTS_RUN;
            act_q   <= '0;
            flush_q <= 1'b0;
        end else begin
            phase_q <= phase_d;
            act_q   <= act_d;
            flush_q <= flush_d;
        end
    end

    // Drive the outputs from registered state
    always_comb begin
        flush_req  = flush_q;
        active_tid = act_q;
        fetch_en   = (phase_q == CTS_RUN);
    end
endmodule

// File: rtl/cts_checker.sv
// Property checker for the thread switcher, attached by bind.
module cts_checker #(
    parameter int NUM_THREADS = 2,
    localparam int TW         = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          miss_valid,
    input logic [TW-1:0] miss_tid,
    input logic          pipe_empty,
    input logic          flush_req,
    input logic [TW-1:0] active_tid,
    input logic          fetch_en
);
    // R2: with no miss, a fetching thread keeps running undisturbed
    a_r2_quiet_run: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en && !miss_valid) |=> (fetch_en && $stable(active_tid) && !flush_req));

    // R3: an accepted miss raises the flush in the following cycle
    a_r3_flush_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en && miss_valid && miss_tid == active_tid) |=> flush_req);

    // R3: the flush lasts a single cycle
    a_r3_flush_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |=> !flush_req);

    // R4: fetch is off while the flush is raised
    a_r4_no_fetch_in_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> !fetch_en);

    // R5: fetch cannot resume while the pipeline still holds work
    a_r5_wait_for_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_en && !pipe_empty) |=> !fetch_en);

    // R6: the active thread is always a real thread
    a_r6_tid_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(active_tid) < NUM_THREADS);
endmodule

bind coarse_thread_switcher cts_checker #(.NUM_THREADS(NUM_THREADS)) u_cts_checker (.*);

// File: tb/tb_coarse_thread_switcher.sv
module tb_coarse_thread_switcher;
    localparam int N   = 4;
    localparam int PEN = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         miss_valid = 1'b0;
    logic [1:0]   miss_tid = '0;
    logic [N-1:0] miss_done = '0;
    logic         pipe_empty = 1'b1;
    logic         flush_req;
    logic [1:0]   active_tid;
    logic         fetch_en;

    int n_chk = 0;
    int n_bad = 0;

    // Reference model: phase 0 run, 1 parked, 2 refill
    int           m_act, m_ph, m_cnt;
    logic [N-1:0] m_blk;
    logic         m_flush;

    always #4 clk = ~clk;  // 125 MHz

    coarse_thread_switcher #(.NUM_THREADS(N), .PENALTY(PEN)) dut (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_tid(miss_tid),
        .miss_done(miss_done), .pipe_empty(pipe_empty), .flush_req(flush_req),
        .active_tid(active_tid), .fetch_en(fetch_en)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // First ready slot after cur, wrapping; -1 if none
    function automatic int rr_pick(input logic [N-1:0] rdy, input int cur);
        for (int k = 1; k <= N; k++) begin
            if (rdy[(cur + k) % N]) return (cur + k) % N;
        end
        return -1;
    endfunction

    task automatic model_edge(input logic mv, input int mt, input logic [N-1:0] md, input logic pe);
        logic [N-1:0] nb;
        bit acc;
        int p;
        acc = (m_ph == 0) && mv && (mt == m_act);
        nb = m_blk & ~md;
        if (acc) nb[m_act] = 1'b1;
        p = rr_pick(~nb, m_act);
        m_flush = 1'b0;
        case (m_ph)
            0: if (acc) begin
                m_flush = 1'b1;
                if (p >= 0) begin m_act = p; m_ph = 2; m_cnt = PEN - 1; end
                else m_ph = 1;
            end
            1: if (p >= 0) begin m_act = p; m_ph = 2; m_cnt = PEN - 1; end
            default: begin
                if (m_cnt == 0 && pe) m_ph = 0;
                else if (m_cnt != 0) m_cnt--;
            end
        endcase
        m_blk = nb;
    endtask

    task automatic compare();
        check(int'(active_tid) == m_act, "R6 active_tid", int'(active_tid), m_act);
        check(fetch_en == (m_ph == 0), "R4 fetch_en", int'(fetch_en), int'(m_ph == 0));
        check(flush_req == m_flush, "R3 flush_req", int'(flush_req), int'(m_flush));
    endtask

    // Drive one cycle of inputs at the falling edge, model the rising edge, compare after
    task automatic step(input logic mv, input int mt, input logic [N-1:0] md, input logic pe);
        miss_valid = mv;
        miss_tid   = 2'(mt);
        miss_done  = md;
        pipe_empty = pe;
        @(posedge clk);
        model_edge(mv, mt, md, pe);
        @(negedge clk);
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 0, '0, 1'b1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : stim
        int seed;
        seed = 32'h1b7;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_act = 0; m_ph = 0; m_cnt = 0; m_blk = '0; m_flush = 1'b0;
        // R1: reset state
        check(active_tid == 2'd0, "R1 active_tid", int'(active_tid), 0);
        check(fetch_en == 1'b1, "R1 fetch_en", int'(fetch_en), 1);
        check(flush_req == 1'b0, "R1 flush_req", int'(flush_req), 0);

        // R2: miss from a thread that is not running
        step(1'b1, 2, '0, 1'b1);
        check(fetch_en && active_tid == 2'd0 && !flush_req, "R2 foreign miss", int'(active_tid), 0);

        // R3/R4/R6: accepted miss on thread 0 moves to thread 1
        step(1'b1, 0, '0, 1'b1);
        check(flush_req == 1'b1, "R3 flush raised", int'(flush_req), 1);
        check(active_tid == 2'd1, "R6 next thread", int'(active_tid), 1);
        idle(1);
        check(flush_req == 1'b0, "R3 flush dropped", int'(flush_req), 0);
        // R9: miss during refill is ignored
        step(1'b1, 1, '0, 1'b1);
        check(active_tid == 2'd1 && !flush_req, "R9 miss in refill", int'(active_tid), 1);
        idle(1);
        // R5: counter expired but pipe busy holds fetch off
        step(1'b0, 0, '0, 1'b0);
        check(fetch_en == 1'b0, "R5 busy pipe", int'(fetch_en), 0);
        step(1'b0, 0, '0, 1'b0);
        check(fetch_en == 1'b0, "R5 busy pipe again", int'(fetch_en), 0);
        idle(1);
        check(fetch_en == 1'b1, "R4 fetch resumes", int'(fetch_en), 1);

        // Chain of misses blocks every thread
        step(1'b1, 1, '0, 1'b1);
        check(active_tid == 2'd2, "R6 step to 2", int'(active_tid), 2);
        idle(PEN);
        step(1'b1, 2, '0, 1'b1);
        check(active_tid == 2'd3, "R6 step to 3", int'(active_tid), 3);
        idle(PEN);
        check(fetch_en == 1'b1, "R4 exact penalty", int'(fetch_en), 1);
        step(1'b1, 3, '0, 1'b1);
        check(active_tid == 2'd3 && !fetch_en && flush_req, "R8 all blocked", int'(active_tid), 3);
        idle(3);
        check(active_tid == 2'd3 && !fetch_en, "R8 parked", int'(fetch_en), 0);
        // R7: releasing thread 1 skips still-blocked thread 0
        step(1'b0, 0, 4'b0010, 1'b1);
        check(active_tid == 2'd1 && !fetch_en, "R7 release picks 1", int'(active_tid), 1);
        idle(PEN);
        check(fetch_en == 1'b1, "R8 resumes after penalty", int'(fetch_en), 1);
        step(1'b0, 0, 4'b1101, 1'b1);

        // Seeded random traffic against the model
        for (int c = 0; c < 4000; c++) begin
            logic mv, pe;
            int mt;
            logic [N-1:0] md;
            mv = ($urandom % 100) < 20;
            mt = (($urandom % 2) == 0) ? m_act : int'($urandom % N);
            pe = ($urandom % 100) < 80;
            md = '0;
            for (int t = 0; t < N; t++) md[t] = ($urandom % 100) < 8;
            step(mv, mt, md, pe);
        end

        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule